// File: doc/BRIEF.md
# Priority Channel Service Scheduler

This block decides which of sixteen timer channels the shared service engine handles next. Each channel can raise service for four independent reasons: a host request, a link from another channel, a match event or a capture event. A one-cycle pulse on any of the four request vectors sets a sticky pending bit for that channel and reason. The host gives every channel a two-bit priority code: disabled, low, middle or high.

Arbitration walks a repeating seven-slot schedule that favours high priority without starving the other levels. Levels with no eligible requester are skipped in the same cycle. Inside a level, channels are served round robin, the lowest number first, and each channel is served once per pass. A winner is presented on the grant outputs with its channel number and a one-hot reason. The grant is held until the engine pulses `done`, which clears every pending bit of that channel.

The control is a two-state machine. In state IDLE the block looks at the pending bits. The transition IDLE to BUSY happens when an eligible requester exists, and the winner is loaded at that edge. The block stays in BUSY while `done` is low. The transition BUSY to IDLE happens on `done`, and it clears the pending bits of the served channel.

Top module: `svc_sched`

## Requirements
- R1: A pulse on `req_host`, `req_link`, `req_match` or `req_capture` bit c sets a pending bit for channel c and that reason. The bit stays set until the channel is served, even while the channel is disabled.
- R2: The priority of channel c is `prio_cfg[2c+1:2c]`: 00 disabled, 01 low, 10 middle, 11 high. A disabled channel is never granted.
- R3: Levels are visited in the repeating slot order high, middle, high, low, high, middle, high. The first slot is used after reset, and after each grant the schedule resumes at the slot that follows the granting slot.
- R4: A slot whose level has no eligible pending channel is skipped without spending a clock cycle.
- R5: Within a level, the grant goes to the lowest-numbered pending channel not yet served in the current pass. When every pending channel of that level has been served, a new pass starts.
- R6: `grant_why` is one-hot, with bit0 host, bit1 link, bit2 match and bit3 capture. When several reasons are pending, the lowest bit is reported, so host beats link, link beats match and match beats capture.
- R7: While `grant_valid` is high and `done` is low, `grant_chan` and `grant_why` stay stable.
- R8: At the edge where `done` is seen with `grant_valid` high, all pending bits of the granted channel are cleared. A request pulse for that channel in the same cycle is kept.
- R9: Suppose a request is sampled at edge k while the block is idle. Then `grant_valid` is high after edge k+1. After the `done` edge, `grant_valid` is low for at least one cycle.
- R10: After reset, `grant_valid`, `grant_chan` and `grant_why` are zero, nothing is pending, the schedule is at its first slot and no channel counts as served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prio_cfg | input | 32 | Two-bit priority code per channel |
| req_host | input | 16 | Host service request pulses |
| req_link | input | 16 | Link request pulses |
| req_match | input | 16 | Match event request pulses |
| req_capture | input | 16 | Capture event request pulses |
| done | input | 1 | Engine finished the granted channel |
| grant_valid | output | 1 | A grant is being presented |
| grant_chan | output | 4 | Granted channel number |
| grant_why | output | 4 | One-hot reason of the grant |

## Verification
The bench fills all levels at once and compares the whole grant order. This catches a schedule that visits levels in the wrong order, or that wastes or misplaces slots when a level is empty. A disabled channel with a request must stay silent, and must then be granted once it is enabled without a new pulse. A design that dropped requests from disabled channels would never produce that grant. Three high channels are served while the first one re-requests in the same cycle as its `done`. The expected order is 0,1,2,0: a design without per-pass fairness would serve channel 0 twice in a row, and one where the clear beats the set would lose the final grant. Channels with several reasons pending must report the highest-ranked reason and then go quiet after one service.

// File: rtl/svc_sched_pkg.sv
package svc_sched_pkg;

    localparam int N_WHY  = 4;
    localparam int SLOT_N = 7;
    localparam int SLOT_W = 3;

    localparam logic [1:0] PRIO_OFF  = 2'b00;
    localparam logic [1:0] PRIO_LOW  = 2'b01;
    localparam logic [1:0] PRIO_MID  = 2'b10;
    localparam logic [1:0] PRIO_HIGH = 2'b11;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } sched_state_e;

    // Slot schedule: even slots high, slots 1 and 5 middle, slot 3 low.
    function automatic logic [1:0] slot_level(input logic [SLOT_W-1:0] s);
        logic [1:0] lv;
        if (!s[0])
            lv = PRIO_HIGH;
        else if (s[1])
            lv = PRIO_LOW;
        else
            lv = PRIO_MID;
        return lv;
    endfunction

endpackage

// File: rtl/svc_lowest.sv
module svc_lowest #(
    parameter int W = 16
) (
    input  logic [W-1:0]                        vec,
    output logic                                found,
    output logic [((W > 1) ? $clog2(W) : 1)-1:0] idx
);
    localparam int IW = (W > 1) ? $clog2(W) : 1;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/svc_pending.sv
module svc_pending
    import svc_sched_pkg::*;
#(
    parameter int N_CH = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [N_CH-1:0]                   set_host,
    input  logic [N_CH-1:0]                   set_link,
    input  logic [N_CH-1:0]                   set_match,
    input  logic [N_CH-1:0]                   set_capture,
    input  logic                              clr_en,
    input  logic [((N_CH > 1) ? $clog2(N_CH) : 1)-1:0] clr_ch,
    output logic [N_CH-1:0][N_WHY-1:0]        pend
);
    localparam int CW = (N_CH > 1) ? $clog2(N_CH) : 1;

    logic [N_CH-1:0][N_WHY-1:0] pend_q;

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        logic [N_WHY-1:0] set_c;
        logic             hit_c;

        assign set_c = {set_capture[c], set_match[c], set_link[c], set_host[c]};
        assign hit_c = clr_en && (clr_ch == CW'(c));

        // Clearing wins over held state, a new set wins over clearing.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                pend_q[c] <= '0;
            else
                pend_q[c] <= (hit_c ? '0 : pend_q[c]) | set_c;
        end

        assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_en && clr_ch == CW'(c)) |=> (pend_q[c] == $past(set_c)));
    end

    assign pend = pend_q;
endmodule

// File: rtl/svc_pick.sv
module svc_pick
    import svc_sched_pkg::*;
#(
    parameter int N_CH = 16
) (
    input  logic [N_CH-1:0][N_WHY-1:0]                 pend,
    input  logic [2*N_CH-1:0]                          prio_cfg,
    input  logic [SLOT_W-1:0]                          slot_ptr,
    input  logic [3:1][N_CH-1:0]                       served,
    output logic                                       pick_ok,
    output logic [((N_CH > 1) ? $clog2(N_CH) : 1)-1:0] pick_chan,
    output logic [N_WHY-1:0]                           pick_why,
    output logic [SLOT_W-1:0]                          pick_slot,
    output logic [1:0]                                 pick_lvl,
    output logic                                       pick_newpass
);
    localparam int CW = (N_CH > 1) ? $clog2(N_CH) : 1;

    logic [3:1][N_CH-1:0] elig;
    logic [3:1][N_CH-1:0] cand;
    logic [3:1]           e_found;
    logic [3:1]           c_found;
    logic [3:1][CW-1:0]   e_idx;
    logic [3:1][CW-1:0]   c_idx;

    // Eligible: pending for any reason and not disabled; split by level.
    always_comb begin
        for (int lv = 1; lv <= 3; lv++) begin
            for (int c = 0; c < N_CH; c++) begin
                elig[lv][c] = (prio_cfg[2*c +: 2] == 2'(lv)) && (|pend[c]);
            end
            cand[lv] = elig[lv] & ~served[lv];
        end
    end

    for (genvar lv = 1; lv <= 3; lv++) begin : g_lvl
        svc_lowest #(.W(N_CH)) u_any (
            .vec   (elig[lv]),
            .found (e_found[lv]),
            .idx   (e_idx[lv])
        );
        svc_lowest #(.W(N_CH)) u_fresh (
            .vec   (cand[lv]),
            .found (c_found[lv]),
            .idx   (c_idx[lv])
        );
    end

    // Look ahead over one full schedule period, first non-empty slot wins.
    always_comb begin
        logic [SLOT_W:0] s;
        logic [1:0]      lv;
        pick_ok   = 1'b0;
        pick_slot = '0;
        pick_lvl  = PRIO_OFF;
        for (int k = 0; k < SLOT_N; k++) begin
            s = {1'b0, slot_ptr} + (SLOT_W+1)'(k);
            if (s >= (SLOT_W+1)'(SLOT_N))
                s = s - (SLOT_W+1)'(SLOT_N);
            lv = slot_level(s[SLOT_W-1:0]);
            if (!pick_ok && e_found[lv]) begin
                pick_ok   = 1'b1;
                pick_slot = s[SLOT_W-1:0];
                pick_lvl  = lv;
            end
        end
    end

    // Channel inside the level and its reported reason.
    always_comb begin
        logic [N_WHY-1:0] r;
        pick_chan    = '0;
        pick_newpass = 1'b0;
        if (pick_ok) begin
            pick_newpass = !c_found[pick_lvl];
            pick_chan    = c_found[pick_lvl] ? c_idx[pick_lvl] : e_idx[pick_lvl];
        end
        r        = pend[pick_chan];
        pick_why = '0;
        for (int i = N_WHY - 1; i >= 0; i--) begin
            if (r[i])
                pick_why = N_WHY'(1) << i;
        end
    end
endmodule

// File: rtl/svc_sched.sv
module svc_sched
    import svc_sched_pkg::*;
#(
    parameter int N_CH = 16
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic [2*N_CH-1:0]                          prio_cfg,
    input  logic [N_CH-1:0]                            req_host,
    input  logic [N_CH-1:0]                            req_link,
    input  logic [N_CH-1:0]                            req_match,
    input  logic [N_CH-1:0]                            req_capture,
    input  logic                                       done,
    output logic                                       grant_valid,
    output logic [((N_CH > 1) ? $clog2(N_CH) : 1)-1:0] grant_chan,
    output logic [N_WHY-1:0]                           grant_why
);
    localparam int CW = (N_CH > 1) ? $clog2(N_CH) : 1;

    sched_state_e               state, state_nxt;
    logic [N_CH-1:0][N_WHY-1:0] pend;
    logic [SLOT_W-1:0]          slot_ptr;
    logic [3:1][N_CH-1:0]       served;
    logic [CW-1:0]              chan_q;
    logic [N_WHY-1:0]           why_q;

    logic                       pick_ok;
    logic [CW-1:0]              pick_chan;
    logic [N_WHY-1:0]           pick_why;
    logic [SLOT_W-1:0]          pick_slot;
    logic [1:0]                 pick_lvl;
    logic                       pick_newpass;
    logic                       take;
    logic                       finish;

    assign take   = (state == ST_IDLE) && pick_ok;
    assign finish = (state == ST_BUSY) && done;

    svc_pending #(.N_CH(N_CH)) u_pend (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_host    (req_host),
        .set_link    (req_link),
        .set_match   (req_match),
        .set_capture (req_capture),
        .clr_en      (finish),
        .clr_ch      (chan_q),
        .pend        (pend)
    );

    svc_pick #(.N_CH(N_CH)) u_pick (
        .pend         (pend),
        .prio_cfg     (prio_cfg),
        .slot_ptr     (slot_ptr),
        .served       (served),
        .pick_ok      (pick_ok),
        .pick_chan    (pick_chan),
        .pick_why     (pick_why),
        .pick_slot    (pick_slot),
        .pick_lvl     (pick_lvl),
        .pick_newpass (pick_newpass)
    );

    // Next-state logic.
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (pick_ok) state_nxt = ST_BUSY;
            ST_BUSY: if (done)    state_nxt = ST_IDLE;
            default:              state_nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nxt;
    end

    // Winner capture, schedule position and per-level pass bookkeeping.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_q   <= '0;
            why_q    <= '0;
            slot_ptr <= '0;
            served   <= '0;
        end else if (take) begin
            chan_q   <= pick_chan;
            why_q    <= pick_why;
            slot_ptr <= (pick_slot == SLOT_W'(SLOT_N - 1)) ? '0 : pick_slot + 1'b1;
            for (int lv = 1; lv <= 3; lv++) begin
                if (pick_lvl == 2'(lv))
                    served[lv] <= (pick_newpass ? '0 : served[lv]) | (N_CH'(1) << pick_chan);
            end
        end
    end

    // Outputs.
    always_comb begin
        unique case (state)
            ST_BUSY: begin
                grant_valid = 1'b1;
                grant_chan  = chan_q;
                grant_why   = why_q;
            end
            default: begin
                grant_valid = 1'b0;
                grant_chan  = '0;
                grant_why   = '0;
            end
        endcase
    end

    assert_legal_pick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (prio_cfg[2*pick_chan +: 2] != PRIO_OFF) && (pend[pick_chan] != '0));

    assert_why_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> ($countones(grant_why) == 1));

    assert_grant_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !done) |=> (grant_valid && $stable(grant_chan) && $stable(grant_why)));

    assert_done_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && done) |=> !grant_valid);

    assert_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (grant_valid && grant_chan == $past(pick_chan)));
endmodule

// File: tb/svc_sched_bench.sv
`timescale 1ns/1ps
module svc_sched_bench;
    localparam int N = 16;

    typedef struct {
        int         ch;
        logic [3:0] why;
        string      tag;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [2*N-1:0]  prio_cfg = '0;
    logic [N-1:0]    drv_host = '0;
    logic [N-1:0]    inj_host = '0;
    logic [N-1:0]    req_host;
    logic [N-1:0]    req_link = '0;
    logic [N-1:0]    req_match = '0;
    logic [N-1:0]    req_capture = '0;
    logic            done = 1'b0;
    logic            grant_valid;
    logic [3:0]      grant_chan;
    logic [3:0]      grant_why;

    exp_t            q[$];
    int              n_chk = 0;
    int              n_fail = 0;
    bit              finished = 0;
    bit              inj_arm = 0;
    logic [3:0]      sp[N];
    logic [1:0]      spr[N];

    always #10 clk = ~clk;
    assign req_host = drv_host | inj_host;

    svc_sched #(.N_CH(N)) u_svc_sched (
        .clk         (clk),
        .rst_n       (rst_n),
        .prio_cfg    (prio_cfg),
        .req_host    (req_host),
        .req_link    (req_link),
        .req_match   (req_match),
        .req_capture (req_capture),
        .done        (done),
        .grant_valid (grant_valid),
        .grant_chan  (grant_chan),
        .grant_why   (grant_why)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Reference model: grant order for a set of requests arriving together.
    task automatic run_model(input string tag);
        logic [3:0] mp[N];
        bit [N-1:0] srv[4];
        int         seq[7] = '{3, 2, 3, 1, 3, 2, 3};
        int         slot = 0;
        for (int c = 0; c < N; c++) mp[c] = sp[c];
        for (int l = 0; l < 4; l++) srv[l] = '0;
        while (1) begin
            bit [N-1:0] el[4];
            bit [N-1:0] cand;
            int         s = -1;
            int         lv;
            int         ch = -1;
            logic [3:0] w = '0;
            for (int l = 0; l < 4; l++) el[l] = '0;
            for (int c = 0; c < N; c++)
                if (spr[c] != 2'b00 && mp[c] != 4'b0) el[spr[c]][c] = 1'b1;
            if ((el[1] | el[2] | el[3]) == '0) break;
            for (int k = 0; k < 7; k++)
                if (s < 0 && el[seq[(slot + k) % 7]] != '0) s = (slot + k) % 7;
            lv   = seq[s];
            cand = el[lv] & ~srv[lv];
            if (cand == '0) begin
                srv[lv] = '0;
                cand    = el[lv];
            end
            for (int c = N - 1; c >= 0; c--) if (cand[c]) ch = c;
            srv[lv][ch] = 1'b1;
            for (int b = 3; b >= 0; b--) if (mp[ch][b]) w = 4'(1 << b);
            q.push_back('{ch, w, tag});
            mp[ch] = '0;
            slot = (s + 1) % 7;
        end
    endtask

    task automatic clear_stim();
        for (int c = 0; c < N; c++) begin
            sp[c]  = '0;
            spr[c] = '0;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Apply priorities, then one request pulse from the stimulus arrays.
    task automatic fire(input bit timing);
        for (int c = 0; c < N; c++) prio_cfg[2*c +: 2] = spr[c];
        @(negedge clk);
        for (int c = 0; c < N; c++) begin
            drv_host[c]    = sp[c][0];
            req_link[c]    = sp[c][1];
            req_match[c]   = sp[c][2];
            req_capture[c] = sp[c][3];
        end
        @(negedge clk);
        drv_host = '0; req_link = '0; req_match = '0; req_capture = '0;
        @(negedge clk);
        if (timing) check(grant_valid === 1'b1, "R9", "grant one cycle after pending", grant_valid, 1);
    endtask

    task automatic wait_quiet(input string tag);
        wait (q.size() == 0);
        repeat (10) @(negedge clk);
        check(grant_valid === 1'b0, tag, "no further grant once served", grant_valid, 0);
    endtask

    // Monitor: pop expected items as grants appear, answer with done.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && grant_valid === 1'b1) begin
                int c0;
                c0 = grant_chan;
                if (q.size() == 0) begin
                    check(1'b0, "R2", "unexpected grant on channel", grant_chan, -1);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(grant_chan == 4'(e.ch), e.tag, "grant channel", grant_chan, e.ch);
                    check(grant_why == e.why, "R6", "grant reason", grant_why, e.why);
                end
                repeat (2) @(negedge clk);
                check(grant_valid === 1'b1 && grant_chan == 4'(c0), "R7", "grant held", grant_chan, c0);
                done = 1'b1;
                if (inj_arm && c0 == 0) begin
                    inj_host = 16'h0001;
                    inj_arm  = 0;
                end
                @(negedge clk);
                done     = 1'b0;
                inj_host = '0;
                check(grant_valid === 1'b0, "R9", "idle cycle after done", grant_valid, 0);
            end
        end
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            summary();
            $finish;
        end
    end

    initial begin
        do_reset();
        // R10: reset state
        check(grant_valid === 1'b0, "R10", "grant_valid after reset", grant_valid, 0);
        check(grant_chan == 4'd0, "R10", "grant_chan after reset", grant_chan, 0);
        check(grant_why == 4'd0, "R10", "grant_why after reset", grant_why, 0);

        // R1/R9: single host request on a high channel
        clear_stim();
        sp[5] = 4'b0001; spr[5] = 2'b11;
        run_model("R1");
        fire(1'b1);
        wait_quiet("R8");

        // R6: reason ranking, link over match/capture, capture alone
        do_reset(); clear_stim();
        sp[3]  = 4'b1110; spr[3]  = 2'b10;
        sp[12] = 4'b1000; spr[12] = 2'b01;
        sp[15] = 4'b0100; spr[15] = 2'b10;
        run_model("R6");
        fire(1'b0);
        wait_quiet("R8");

        // R8: all four reasons on one channel, served once then cleared
        do_reset(); clear_stim();
        sp[7] = 4'b1111; spr[7] = 2'b01;
        run_model("R6");
        fire(1'b0);
        wait_quiet("R8");

        // R3: full schedule order across three levels
        do_reset(); clear_stim();
        for (int c = 1; c <= 4; c++) begin sp[c] = 4'b0001; spr[c] = 2'b11; end
        sp[5] = 4'b0010; spr[5] = 2'b10;
        sp[6] = 4'b0100; spr[6] = 2'b10;
        sp[7] = 4'b1000; spr[7] = 2'b01;
        run_model("R3");
        fire(1'b0);
        wait_quiet("R3");

        // R4/R2: empty high level skipped, disabled channel stays silent
        do_reset(); clear_stim();
        sp[9]  = 4'b0100; spr[9]  = 2'b01;
        sp[10] = 4'b0001; spr[10] = 2'b10;
        sp[11] = 4'b1000; spr[11] = 2'b10;
        run_model("R4");
        sp[0] = 4'b0001; spr[0] = 2'b00;
        fire(1'b0);
        wait_quiet("R2");

        // R1: enabling the channel later serves the request still pending
        q.push_back('{0, 4'b0001, "R1"});
        prio_cfg[1:0] = 2'b11;
        wait_quiet("R8");

        // R5/R8: round robin in one level, re-request at done kept
        do_reset(); clear_stim();
        for (int c = 0; c <= 2; c++) begin sp[c] = 4'b0001; spr[c] = 2'b11; end
        q.push_back('{0, 4'b0001, "R5"});
        q.push_back('{1, 4'b0001, "R5"});
        q.push_back('{2, 4'b0001, "R5"});
        q.push_back('{0, 4'b0001, "R8"});
        inj_arm = 1;
        fire(1'b0);
        wait_quiet("R5");

        finished = 1;
        summary();
        $finish;
    end
endmodule